// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down counters behind a byte-wide register bus with a two-bit address. The first three addresses reach the data registers of channels 0, 1 and 2. The fourth address takes a control byte. That byte picks a channel and sets how its count is moved over the bus, which of six counting modes it runs and whether it counts in binary or in BCD. Software sets up a channel by writing a control byte. It then writes the initial count one byte at a time. It can read the count while the channel runs, either live or through a frozen snapshot taken by a latch command.

Each channel has a count-enable input `ch_tick`, a `ch_gate` input and an output `ch_out`. All three are synchronous to the single block clock. One cycle with `ch_tick` high counts as one count clock for that channel. The gate holds the count, or triggers or restarts it, depending on the mode. The output carries terminal-count levels, one-shot pulses, rate pulses, square waves or strobes.

The bus has no stream handshake. Every strobe is taken in the cycle it is presented and there is no back-pressure. Read data is registered and appears one cycle after the read strobe.

Top module: `pit3_timer`

## Requirements
- R1: `bus_rdata` is loaded on the clock edge that samples `bus_rd` and holds its value otherwise. A read of address 3 returns 0x00. A control byte whose select field is 2'b11 has no effect on any channel.
- R2: Control byte fields: [7:6] select the channel (00, 01, 10). [5:4] set the access pattern: 00 latch, 01 low byte only, 10 high byte only, 11 both bytes with the low byte first. [3:1] set the mode: 000 terminal count, 001 one-shot, 010 rate, 011 square, 100 software strobe, 101 hardware strobe, with 110 and 111 acting as 010 and 011. [0] set selects BCD.
- R3: A control byte with a non-latch access pattern drives that channel's output to its initial level on the next edge: low in mode 0, high in all other modes. The channel stops counting until the whole initial count has been written, and both byte toggles return to the low byte.
- R4: With the both-bytes pattern, data writes and data reads each alternate low byte then high byte. A low-only write loads {8'h00, byte}. A high-only write loads {byte, 8'h00}. Low-only and high-only reads return the matching byte of the count.
- R5: A latch command copies the count into a snapshot that later reads return. The snapshot is held until all of its bytes have been read, further latch commands are ignored until then, and the running count is not disturbed.
- R6: Reads with no snapshot held return the live count.
- R7: In BCD the count steps down through four decimal digits, so 0100 becomes 0099 and 0000 becomes 9999. In binary, 0000 becomes FFFF. A loaded 0 therefore spans the maximum count.
- R8: Mode 0: the output is low after the load and goes high on the tick at which the count reaches 0. Ticks count only while the gate is high.
- R9: Mode 1: after the load the output stays high. A gate rising edge reloads the count and drives the output low. It goes high again on the tick at which the count reaches 0.
- R10: Mode 2 with initial count N of 2 or more: the output is low for exactly the one tick period in which the count is 1, and the count then reloads N, giving a period of N ticks.
- R11: Mode 3 with initial count N of 2 or more: the output is high for ceil(N/2) ticks and low for floor(N/2) ticks, repeating.
- R12: Mode 4: once loaded, counting proceeds while the gate is high. The output goes low for one tick period when the count first reaches 0, then stays high.
- R13: Mode 5: ticks do nothing until a gate rising edge. That edge reloads the count, and from then on the output behaves as in mode 4 whatever the gate does.
- R14: A channel's output changes only after its own tick, a bus write, a gate rising edge or a low gate. In modes 2 and 3 a low gate holds the count and forces the output high. Ticks on one channel never affect another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0..2 channel data, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| ch_tick | input | 3 | Per-channel count enable, one pulse per count clock |
| ch_gate | input | 3 | Per-channel gate |
| ch_out | output | 3 | Per-channel timer output |

## Verification
The properties assume that `bus_wr` and `bus_rd` are never high together and that `ch_tick` is a clean one-cycle enable per count clock. They also assume that modes 2 and 3 are never given an initial count of 1. The bench drives every bus access as a single-cycle strobe from one task, so the two strobes can never overlap. Ticks are issued from a task as isolated one-cycle pulses, and every rate or square-wave load uses counts of 3 or more. The random phase keeps all gates low so that byte sequencing and latching are checked against a count that stands still.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 16;
  localparam int SPAN_W  = CNT_W + 1;
  localparam int DIGITS  = CNT_W / 4;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_e;

  typedef enum logic [2:0] {
    M_TERM   = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE   = 3'd2,
    M_SQUARE = 3'd3,
    M_SWSTB  = 3'd4,
    M_HWSTB  = 3'd5
  } mode_e;

  // Fields 110 and 111 fold onto the rate and square modes.
  function automatic mode_e decode_mode(input logic [2:0] f);
    if (f[2:1] == 2'b11) return mode_e'({1'b0, f[1:0]});
    return mode_e'(f);
  endfunction

  // Decimal step-down, one nibble per digit, borrow rippling upward.
  function automatic logic [CNT_W-1:0] bcd_step(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    logic borrow;
    borrow = 1'b1;
    r = v;
    for (int d = 0; d < DIGITS; d++) begin
      if (borrow) begin
        if (v[4*d +: 4] == 4'd0) r[4*d +: 4] = 4'd9;
        else begin
          r[4*d +: 4] = v[4*d +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // Number of count clocks a loaded value spans, with 0 meaning full range.
  function automatic logic [SPAN_W-1:0] count_span(input logic [CNT_W-1:0] v, input logic bcd);
    if (v == '0) return bcd ? SPAN_W'(10000) : SPAN_W'(1) << CNT_W;
    if (!bcd) return SPAN_W'(v);
    return SPAN_W'(v[15:12]) * SPAN_W'(1000) + SPAN_W'(v[11:8]) * SPAN_W'(100)
         + SPAN_W'(v[7:4]) * SPAN_W'(10) + SPAN_W'(v[3:0]);
  endfunction
endpackage

// File: rtl/pit_engine.sv
module pit_engine
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  mode_e            cfg_mode,
  input  logic             cfg_bcd,
  input  logic             commit,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             gate,
  input  logic             gate_rise,
  output logic [CNT_W-1:0] count,
  output logic             out
);
  mode_e            mode;
  logic             bcd, armed, trig, fired;
  logic [CNT_W-1:0] reload;
  logic [SPAN_W-1:0] half_ctr;
  logic [CNT_W-1:0] nxt;
  logic [SPAN_W-1:0] span_r, span_hi, span_lo, span_new;

  assign nxt      = bcd ? bcd_step(count) : count - CNT_W'(1);
  assign span_r   = count_span(reload, bcd);
  assign span_hi  = (span_r + SPAN_W'(1)) >> 1;
  assign span_lo  = span_r >> 1;
  assign span_new = (count_span(load_val, bcd) + SPAN_W'(1)) >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= M_TERM;
      bcd      <= 1'b0;
      armed    <= 1'b0;
      trig     <= 1'b0;
      fired    <= 1'b0;
      reload   <= '0;
      count    <= '0;
      half_ctr <= '0;
      out      <= 1'b0;
    end else if (cfg_we) begin
      mode  <= cfg_mode;
      bcd   <= cfg_bcd;
      armed <= 1'b0;
      out   <= (cfg_mode != M_TERM);
    end else if (commit) begin
      reload   <= load_val;
      count    <= load_val;
      armed    <= 1'b1;
      trig     <= 1'b0;
      fired    <= 1'b0;
      half_ctr <= span_new;
      out      <= (mode != M_TERM);
    end else if (armed) begin
      case (mode)
        M_TERM: begin
          if (tick && gate) begin
            count <= nxt;
            if (nxt == '0) out <= 1'b1;
          end
        end
        M_ONESHOT: begin
          if (gate_rise) begin
            count <= reload;
            trig  <= 1'b1;
            out   <= 1'b0;
          end else if (tick && trig) begin
            count <= nxt;
            if (nxt == '0) out <= 1'b1;
          end
        end
        M_RATE: begin
          if (!gate) out <= 1'b1;
          else if (gate_rise) begin
            count <= reload;
            out   <= 1'b1;
          end else if (tick) begin
            if (count == CNT_W'(1)) begin
              count <= reload;
              out   <= 1'b1;
            end else begin
              count <= nxt;
              out   <= (nxt != CNT_W'(1));
            end
          end
        end
        M_SQUARE: begin
          if (!gate) out <= 1'b1;
          else if (gate_rise) begin
            count    <= reload;
            out      <= 1'b1;
            half_ctr <= span_hi;
          end else if (tick) begin
            count <= (count == CNT_W'(1)) ? reload : nxt;
            if (half_ctr == SPAN_W'(1)) begin
              out      <= ~out;
              half_ctr <= out ? span_lo : span_hi;
            end else begin
              half_ctr <= half_ctr - SPAN_W'(1);
            end
          end
        end
        M_SWSTB, M_HWSTB: begin
          if (mode == M_HWSTB && gate_rise) begin
            count <= reload;
            trig  <= 1'b1;
            fired <= 1'b0;
            out   <= 1'b1;
          end else if (tick && (mode == M_HWSTB ? trig : gate)) begin
            count <= nxt;
            if (!out) out <= 1'b1;
            else if (nxt == '0 && !fired) begin
              out   <= 1'b0;
              fired <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tick,
  input  logic              gate,
  input  logic              gate_rise,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [CNT_W-1:0]  snap,
  output logic              latched,
  output logic              out
);
  acc_e              acc;
  logic              wr_hi, rd_hi;
  logic [BYTE_W-1:0] lsb_hold;
  logic [CNT_W-1:0]  count, load_val, src;
  logic              cfg_we, latch_cmd, commit;
  acc_e              acc_in;

  assign acc_in    = acc_e'(wdata[5:4]);
  assign cfg_we    = ctrl_we && (acc_in != ACC_LATCH);
  assign latch_cmd = ctrl_we && (acc_in == ACC_LATCH);
  assign commit    = data_we && (acc != ACC_BOTH || wr_hi);

  always_comb begin
    case (acc)
      ACC_LO:  load_val = {{BYTE_W{1'b0}}, wdata};
      ACC_HI:  load_val = {wdata, {BYTE_W{1'b0}}};
      default: load_val = {wdata, lsb_hold};
    endcase
  end

  assign src     = latched ? snap : count;
  assign rd_byte = (acc == ACC_HI || (acc == ACC_BOTH && rd_hi)) ? src[CNT_W-1 -: BYTE_W]
                                                                 : src[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= ACC_BOTH;
      wr_hi    <= 1'b0;
      rd_hi    <= 1'b0;
      lsb_hold <= '0;
      latched  <= 1'b0;
      snap     <= '0;
    end else if (cfg_we) begin
      acc     <= acc_in;
      wr_hi   <= 1'b0;
      rd_hi   <= 1'b0;
      latched <= 1'b0;
    end else begin
      if (latch_cmd && !latched) begin
        latched <= 1'b1;
        snap    <= count;
      end
      if (data_we && acc == ACC_BOTH) begin
        if (!wr_hi) lsb_hold <= wdata;
        wr_hi <= ~wr_hi;
      end
      if (data_re) begin
        if (acc == ACC_BOTH) rd_hi <= ~rd_hi;
        if (latched && (acc != ACC_BOTH || rd_hi)) latched <= 1'b0;
      end
    end
  end

  pit_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_mode  (decode_mode(wdata[3:1])),
    .cfg_bcd   (wdata[0]),
    .commit    (commit),
    .load_val  (load_val),
    .tick      (tick),
    .gate      (gate),
    .gate_rise (gate_rise),
    .count     (count),
    .out       (out)
  );
endmodule

// File: rtl/pit3_timer.sv
module pit3_timer
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] ch_tick,
  input  logic [NUM_CH-1:0] ch_gate,
  output logic [NUM_CH-1:0] ch_out
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic [NUM_CH-1:0]              gate_q, gate_rise, latched;
  logic [NUM_CH-1:0][BYTE_W-1:0]  rd_byte;
  logic [NUM_CH-1:0][CNT_W-1:0]   snap;

  assign gate_rise = ch_gate & ~gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= ch_gate;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      bus_rdata <= '0;
      for (int c = 0; c < NUM_CH; c++)
        if (bus_addr == 2'(c)) bus_rdata <= rd_byte[c];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pit_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (bus_wr && bus_addr == CTRL_ADDR && bus_wdata[7:6] == 2'(c)),
      .data_we   (bus_wr && bus_addr == 2'(c)),
      .data_re   (bus_rd && bus_addr == 2'(c)),
      .wdata     (bus_wdata),
      .tick      (ch_tick[c]),
      .gate      (ch_gate[c]),
      .gate_rise (gate_rise[c]),
      .rd_byte   (rd_byte[c]),
      .snap      (snap[c]),
      .latched   (latched[c]),
      .out       (ch_out[c])
    );
  end
endmodule

// File: rtl/pit3_timer_checker.sv
module pit3_timer_checker
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [1:0]                       bus_addr,
  input logic                             bus_wr,
  input logic                             bus_rd,
  input logic [BYTE_W-1:0]                bus_wdata,
  input logic [BYTE_W-1:0]                bus_rdata,
  input logic [NUM_CH-1:0]                ch_tick,
  input logic [NUM_CH-1:0]                ch_gate,
  input logic [NUM_CH-1:0]                ch_out,
  input logic [NUM_CH-1:0]                gate_rise,
  input logic [NUM_CH-1:0][CNT_W-1:0]     snap,
  input logic [NUM_CH-1:0]                latched
);
  a_r1_ctrl_port_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 2'd3 |=> bus_rdata == '0);

  a_r1_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    a_r3_ctrl_sets_level: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == 2'd3 && bus_wdata[7:6] == 2'(k) && bus_wdata[5:4] != 2'b00
      |=> ch_out[k] == ($past(bus_wdata[3:1]) != 3'b000));

    a_r5_snapshot_stable: assert property (@(posedge clk) disable iff (!rst_n)
      latched[k] |=> $stable(snap[k]));

    a_r5_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
      latched[k] && !bus_rd && !(bus_wr && bus_addr == 2'd3) |=> latched[k]);

    a_r14_out_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(ch_out[k]) |-> $past(ch_tick[k] || bus_wr || gate_rise[k] || !ch_gate[k]));
  end
endmodule

bind pit3_timer pit3_timer_checker #(.NUM_CH(NUM_CH)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ch_tick   (ch_tick),
  .ch_gate   (ch_gate),
  .ch_out    (ch_out),
  .gate_rise (gate_rise),
  .snap      (snap),
  .latched   (latched)
);

// File: tb/pit3_timer_tb.sv
module pit3_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] ch_tick = '0, ch_gate = '0;
  logic [2:0] ch_out;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pit3_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_tick(ch_tick), .ch_gate(ch_gate),
    .ch_out(ch_out)
  );

  function automatic logic [7:0] ctrl_byte(int ch, int acc, int mode, bit bcd);
    return {2'(ch), 2'(acc), 3'(mode), bcd};
  endfunction

  function automatic logic [15:0] single_load(int acc, logic [15:0] v);
    if (acc == 1) return {8'h00, v[7:0]};
    if (acc == 2) return {v[15:8], 8'h00};
    return v;
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(int a, logic [7:0] d);
    @(negedge clk); bus_addr = 2'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(int a, output logic [7:0] d);
    @(negedge clk); bus_addr = 2'(a); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic load16(int ch, logic [15:0] v);
    bus_write(ch, v[7:0]);
    bus_write(ch, v[15:8]);
  endtask

  task automatic read16(int ch, output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_read(ch, lo);
    bus_read(ch, hi);
    v = {hi, lo};
  endtask

  task automatic tick_n(int ch, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ch_tick[ch] = 1'b1;
      @(negedge clk); ch_tick[ch] = 1'b0;
    end
  endtask

  task automatic set_gate(int ch, bit v);
    @(negedge clk); ch_gate[ch] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    logic [2:0]  outs;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    check("reset outputs", 16'(ch_out), 16'h0);
    bus_read(3, b);
    check("R1 control port read", 16'(b), 16'h00);

    // R2 R3 R8: mode 0, binary, count 5
    ch_gate[0] = 1'b1;
    bus_write(3, ctrl_byte(0, 3, 0, 0));
    check("R3 mode 0 initial low", 16'(ch_out[0]), 16'h0);
    load16(0, 16'd5);
    tick_n(0, 4);
    read16(0, v);
    check("R8 count after 4 ticks", v, 16'd1);
    check("R8 out still low", 16'(ch_out[0]), 16'h0);
    tick_n(0, 1);
    check("R8 out high at zero", 16'(ch_out[0]), 16'h1);

    // R3: counting waits for the whole count
    ch_gate[2] = 1'b1;
    bus_write(3, ctrl_byte(2, 3, 0, 0));
    bus_write(2, 8'h10);
    tick_n(2, 3);
    check("R3 out low during partial load", 16'(ch_out[2]), 16'h0);
    bus_write(2, 8'h00);
    read16(2, v);
    check("R3 no count before full load", v, 16'h0010);
    tick_n(2, 1);
    read16(2, v);
    check("R3 counts after full load", v, 16'h000F);

    // R7: BCD and binary step-down with the zero count
    ch_gate[1] = 1'b1;
    bus_write(3, ctrl_byte(1, 3, 0, 1));
    load16(1, 16'h0100);
    tick_n(1, 1);
    read16(1, v);
    check("R7 bcd 0100 step", v, 16'h0099);
    load16(1, 16'h0000);
    tick_n(1, 1);
    read16(1, v);
    check("R7 bcd zero wraps", v, 16'h9999);
    bus_write(3, ctrl_byte(1, 3, 0, 0));
    load16(1, 16'h0000);
    tick_n(1, 1);
    read16(1, v);
    check("R7 binary zero wraps", v, 16'hFFFF);

    // R4: single-byte access patterns
    ch_gate[2] = 1'b0;
    bus_write(3, ctrl_byte(2, 2, 0, 0));
    bus_write(2, 8'h12);
    bus_read(2, b);
    check("R4 high-only read", 16'(b), 16'h12);
    bus_write(3, ctrl_byte(2, 3, 0, 0));
    read16(2, v);
    check("R4 high-only load zeroes low byte", v, 16'h1200);
    bus_write(3, ctrl_byte(2, 1, 0, 0));
    bus_write(2, 8'h34);
    bus_read(2, b);
    check("R4 low-only read", 16'(b), 16'h34);
    bus_write(3, ctrl_byte(2, 3, 0, 0));
    read16(2, v);
    check("R4 low-only load zeroes high byte", v, 16'h0034);

    // R5 R6: latched reads
    bus_write(3, ctrl_byte(0, 3, 0, 0));
    load16(0, 16'h1000);
    bus_write(3, ctrl_byte(0, 0, 0, 0));
    tick_n(0, 5);
    read16(0, v);
    check("R5 snapshot value", v, 16'h1000);
    read16(0, v);
    check("R6 live count after release", v, 16'h0FFB);
    bus_write(3, ctrl_byte(0, 0, 0, 0));
    tick_n(0, 2);
    bus_write(3, ctrl_byte(0, 0, 0, 0));
    tick_n(0, 2);
    read16(0, v);
    check("R5 second latch ignored", v, 16'h0FFB);
    read16(0, v);
    check("R5 running count undisturbed", v, 16'h0FF7);

    // R10: rate mode, N = 4
    ch_gate[1] = 1'b1;
    bus_write(3, ctrl_byte(1, 3, 2, 0));
    check("R3 rate initial high", 16'(ch_out[1]), 16'h1);
    load16(1, 16'd4);
    tick_n(1, 2);
    check("R10 high before count 1", 16'(ch_out[1]), 16'h1);
    tick_n(1, 1);
    check("R10 low at count 1", 16'(ch_out[1]), 16'h0);
    tick_n(1, 1);
    check("R10 high after reload", 16'(ch_out[1]), 16'h1);
    read16(1, v);
    check("R10 reloaded count", v, 16'd4);
    tick_n(1, 1);
    set_gate(1, 1'b0);
    tick_n(1, 3);
    read16(1, v);
    check("R14 gate low holds rate count", v, 16'd3);
    check("R14 gate low forces high", 16'(ch_out[1]), 16'h1);

    // R11: square wave, N = 5
    ch_gate[2] = 1'b1;
    bus_write(3, ctrl_byte(2, 3, 3, 0));
    load16(2, 16'd5);
    tick_n(2, 2);
    check("R11 high phase continues", 16'(ch_out[2]), 16'h1);
    tick_n(2, 1);
    check("R11 low after 3 ticks", 16'(ch_out[2]), 16'h0);
    tick_n(2, 1);
    check("R11 low phase continues", 16'(ch_out[2]), 16'h0);
    tick_n(2, 1);
    check("R11 high after 2 low ticks", 16'(ch_out[2]), 16'h1);

    // R12: software strobe, N = 3
    ch_gate[0] = 1'b1;
    bus_write(3, ctrl_byte(0, 3, 4, 0));
    load16(0, 16'd3);
    tick_n(0, 2);
    check("R12 high before zero", 16'(ch_out[0]), 16'h1);
    tick_n(0, 1);
    check("R12 strobe low at zero", 16'(ch_out[0]), 16'h0);
    tick_n(0, 1);
    check("R12 strobe one tick", 16'(ch_out[0]), 16'h1);
    tick_n(0, 3);
    check("R12 single strobe", 16'(ch_out[0]), 16'h1);

    // R13: hardware strobe, N = 2
    ch_gate[1] = 1'b0;
    bus_write(3, ctrl_byte(1, 3, 5, 0));
    load16(1, 16'd2);
    tick_n(1, 3);
    read16(1, v);
    check("R13 idle until trigger", v, 16'd2);
    set_gate(1, 1'b1);
    tick_n(1, 1);
    check("R13 high after one tick", 16'(ch_out[1]), 16'h1);
    tick_n(1, 1);
    check("R13 strobe low", 16'(ch_out[1]), 16'h0);
    tick_n(1, 1);
    check("R13 strobe ends", 16'(ch_out[1]), 16'h1);

    // R9: one-shot, N = 3
    ch_gate[2] = 1'b0;
    bus_write(3, ctrl_byte(2, 3, 1, 0));
    load16(2, 16'd3);
    check("R9 high after load", 16'(ch_out[2]), 16'h1);
    set_gate(2, 1'b1);
    check("R9 low on trigger", 16'(ch_out[2]), 16'h0);
    tick_n(2, 2);
    check("R9 low while counting", 16'(ch_out[2]), 16'h0);
    tick_n(2, 1);
    check("R9 high at zero", 16'(ch_out[2]), 16'h1);

    // R1: select 11 ignored; R2: mode alias 110 acts as rate
    outs = ch_out;
    bus_write(3, 8'hF0);
    check("R1 select 11 ignored", 16'(ch_out), 16'(outs));
    ch_gate[0] = 1'b1;
    bus_write(3, ctrl_byte(0, 3, 6, 0));
    load16(0, 16'd3);
    tick_n(0, 2);
    check("R2 mode 110 acts as rate", 16'(ch_out[0]), 16'h0);

    // R4 R6 R14: random byte sequencing with gates low
    ch_gate = '0;
    @(negedge clk);
    for (int it = 0; it < 40; it++) begin
      int ch, acc;
      logic [15:0] val, exp;
      bit use_latch;
      ch  = int'($urandom % 3);
      acc = 1 + int'($urandom % 3);
      val = 16'($urandom);
      use_latch = bit'($urandom % 2);
      bus_write(3, ctrl_byte(ch, acc, 0, 0));
      if (acc == 3) load16(ch, val);
      else bus_write(ch, acc == 1 ? val[7:0] : val[15:8]);
      exp = single_load(acc, val);
      tick_n(ch, int'($urandom % 3));
      tick_n((ch + 1) % 3, 2);
      if (use_latch) bus_write(3, ctrl_byte(ch, 0, 0, 0));
      if (acc == 3) begin
        read16(ch, v);
        check("R4 R6 random both-byte read", v, exp);
      end else begin
        bus_read(ch, b);
        check("R4 R14 random single-byte read", 16'(b),
              16'(acc == 1 ? exp[7:0] : exp[15:8]));
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule